// File: doc/BRIEF.md
# Chained Byte Stream Scrambler

This block obscures or restores a stream of bytes, handling one byte per accepted handshake. Two 8-bit chaining registers carry history from byte to byte, so the same plaintext byte maps to different ciphertext bytes depending on what came before it. Each byte passes through a fixed chain of wrap-around additions, subtractions and XORs with constants, and the two chaining values are mixed into that chain.

A direction input selects scrambling (forward) or unscrambling (inverse) for each accepted byte. A start-of-message flag, sampled with the byte it marks, restarts the chain from fixed seed values. A message holds 1 to 64 bytes. The result comes out of a single registered output stage with a valid/ready handshake, so the output can be stalled. Feeding a forward-mode message back through the block in inverse mode restores the original bytes.

Top module: `byte_chain_scrambler`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: In forward mode (`dir`=0), with chain values A and B, the output is computed in two parts, all arithmetic modulo 256. First t = (((x ^ B ^ 0x2B) - 0x05) ^ 0x35) - 0x39. Then y = (((t ^ A ^ 0x5A) - 0xB0) ^ 0x38) - 0x45.
- R3: After a forward-mode byte is accepted, A holds the input byte and B holds the output byte just produced.
- R4: In inverse mode (`dir`=1), first u = ((((x + 0x45) ^ 0x38) + 0xB0) ^ 0x5A) ^ A. Then y = ((((u + 0x39) ^ 0x35) + 0x05) ^ 0x2B) ^ B.
- R5: After an inverse-mode byte is accepted, A holds the recovered output byte and B holds the input byte.
- R6: A byte accepted with `in_sop`=1 is processed with A=0x9B and B=0x54 instead of the stored values. The same seeds are loaded by reset, so the first byte after reset sees them even without `in_sop`.
- R7: A byte accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid`=1 right after that edge, giving a latency of one cycle.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R9: Scrambling a message of 1 to 64 bytes in forward mode and then passing the result through the block in inverse mode as a new message returns the original bytes.
- R10: A cycle with no accepted byte leaves both chaining values unchanged. This is seen at the ports as the output of the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | 0 = forward (scramble), 1 = inverse (unscramble); sampled with each byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_sop | input | 1 | Marks the first byte of a message; restarts the chain |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |

## Verification
The hardest cases to reach from the ports combine a stall with the chain state. One is a start flag that arrives while the output is blocked, so the byte waits in front of `in_ready` and must still use the seeds when it is finally taken. The other is a run of idle or stalled cycles that must leave the chain untouched. The random phase holds `out_ready` low for long stretches, drops `in_valid` between bytes, and changes direction and message length from message to message. A behavioural model checks every cycle. A directed loopback then scrambles 1-byte and 64-byte messages and unscrambles them again.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } dir_e;

  localparam byte_t SEED_A = 8'h9B;
  localparam byte_t SEED_B = 8'h54;

  localparam byte_t K_X0 = 8'h2B;
  localparam byte_t K_S0 = 8'h05;
  localparam byte_t K_X1 = 8'h35;
  localparam byte_t K_S1 = 8'h39;
  localparam byte_t K_X2 = 8'h5A;
  localparam byte_t K_S2 = 8'hB0;
  localparam byte_t K_X3 = 8'h38;
  localparam byte_t K_S3 = 8'h45;
endpackage

// File: rtl/bcs_fwd_path.sv
module bcs_fwd_path
  import bcs_pkg::*;
(
  input  byte_t din,
  input  byte_t key_a,
  input  byte_t key_b,
  output byte_t dout
);
  byte_t mid;

  always_comb begin
    mid  = (((din ^ key_b ^ K_X0) - K_S0) ^ K_X1) - K_S1;
    dout = (((mid ^ key_a ^ K_X2) - K_S2) ^ K_X3) - K_S3;
  end
endmodule

// File: rtl/bcs_inv_path.sv
module bcs_inv_path
  import bcs_pkg::*;
(
  input  byte_t din,
  input  byte_t key_a,
  input  byte_t key_b,
  output byte_t dout
);
  byte_t mid;

  always_comb begin
    mid  = ((((din + K_S3) ^ K_X3) + K_S2) ^ K_X2) ^ key_a;
    dout = ((((mid + K_S1) ^ K_X1) + K_S0) ^ K_X0) ^ key_b;
  end
endmodule

// File: rtl/bcs_chain_regs.sv
module bcs_chain_regs
  import bcs_pkg::*;
#(
  parameter byte_t INIT_A = SEED_A,
  parameter byte_t INIT_B = SEED_B
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  restart,
  input  dir_e  dir,
  input  byte_t din,
  input  byte_t result,
  output byte_t cur_a,
  output byte_t cur_b
);
  byte_t reg_a, reg_b;

  assign cur_a = restart ? INIT_A : reg_a;
  assign cur_b = restart ? INIT_B : reg_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= INIT_A;
      reg_b <= INIT_B;
    end else if (load) begin
      if (dir == DIR_FWD) begin
        reg_a <= din;
        reg_b <= result;
      end else begin
        reg_a <= result;
        reg_b <= din;
      end
    end
  end

  // R3
  fwd_update_chk: assert property (@(posedge clk) disable iff (rst)
    (load && dir == DIR_FWD) |=> (reg_a == $past(din) && reg_b == $past(result)));

  // R5
  inv_update_chk: assert property (@(posedge clk) disable iff (rst)
    (load && dir == DIR_INV) |=> (reg_a == $past(result) && reg_b == $past(din)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

// File: rtl/bcs_out_stage.sv
module bcs_out_stage
  import bcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  offer,
  input  byte_t din,
  output logic  take,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_data
);
  assign take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= offer;
      if (offer) out_data <= din;
    end
  end

  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    (offer && take) |=> (out_valid && out_data == $past(din)));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !offer) |=> !out_valid);
endmodule

// File: rtl/byte_chain_scrambler.sv
module byte_chain_scrambler
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dir,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sop,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);
  dir_e  dir_sel;
  byte_t key_a, key_b, fwd_res, inv_res, result;
  logic  accept;

  assign dir_sel = dir_e'(dir);
  assign accept  = in_valid && in_ready;
  assign result  = (dir_sel == DIR_FWD) ? fwd_res : inv_res;

  bcs_chain_regs #(.INIT_A(SEED_A), .INIT_B(SEED_B)) u_chain (
    .clk(clk), .rst(rst), .load(accept), .restart(in_sop), .dir(dir_sel),
    .din(in_data), .result(result), .cur_a(key_a), .cur_b(key_b)
  );

  bcs_fwd_path u_fwd (.din(in_data), .key_a(key_a), .key_b(key_b), .dout(fwd_res));
  bcs_inv_path u_inv (.din(in_data), .key_a(key_a), .key_b(key_b), .dout(inv_res));

  bcs_out_stage u_out (
    .clk(clk), .rst(rst), .offer(in_valid), .din(result), .take(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R6
  sop_seed_chk: assert property (@(posedge clk) disable iff (rst)
    in_sop |-> (key_a == SEED_A && key_b == SEED_B));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

// File: tb/byte_chain_scrambler_tb.sv
module byte_chain_scrambler_tb;
  logic clk = 1'b0;
  logic rst, dir, in_valid, in_ready, in_sop, out_valid, out_ready;
  logic [7:0] in_data, out_data;

  always #2 clk = ~clk;

  byte_chain_scrambler u_dut (
    .clk(clk), .rst(rst), .dir(dir), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] ma, mb, m_d;
  logic m_v;
  string m_tag;
  logic [7:0] rxq[$];

  function automatic logic [7:0] fwd(input logic [7:0] x, a, b);
    logic [7:0] t;
    t = x ^ b ^ 8'h2B; t = t - 8'h05; t = t ^ 8'h35; t = t - 8'h39;
    t = t ^ a ^ 8'h5A; t = t - 8'hB0; t = t ^ 8'h38; t = t - 8'h45;
    return t;
  endfunction

  function automatic logic [7:0] inv(input logic [7:0] x, a, b);
    logic [7:0] t;
    t = x + 8'h45; t = t ^ 8'h38; t = t + 8'hB0; t = t ^ 8'h5A ^ a;
    t = t + 8'h39; t = t ^ 8'h35; t = t + 8'h05; t = t ^ 8'h2B ^ b;
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: called at a negedge, returns at the next negedge
  task automatic cycle(input logic iv, input logic [7:0] d, input logic s,
                       input logic md, input logic r);
    logic rdy;
    logic [7:0] ka, kb, y;
    in_valid = iv; in_data = d; in_sop = s; dir = md; out_ready = r;
    #1;
    rdy = !m_v || r;
    chk(in_ready == rdy, "R8 in_ready", in_ready, rdy);
    if (m_v && r) rxq.push_back(m_d);
    if (iv && rdy) begin
      ka = s ? 8'h9B : ma;
      kb = s ? 8'h54 : mb;
      if (md == 1'b0) begin
        y = fwd(d, ka, kb); ma = d; mb = y;
        m_tag = s ? "R6 R2 R3" : "R2 R3 R10";
      end else begin
        y = inv(d, ka, kb); ma = y; mb = d;
        m_tag = s ? "R6 R4 R5" : "R4 R5 R10";
      end
      m_v = 1'b1; m_d = y;
    end else if (r) begin
      m_v = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == m_v, "R7 out_valid", out_valid, m_v);
    if (m_v) chk(out_data == m_d, m_tag, out_data, m_d);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  // send a whole message at full rate, collecting output into rxq
  task automatic send_msg(input logic [7:0] msg[$], input logic md);
    rxq.delete();
    for (int i = 0; i < msg.size(); i++) cycle(1'b1, msg[i], i == 0, md, 1'b1);
    flush();
  endtask

  task automatic loopback(input int len);
    logic [7:0] pt[$], ct[$];
    for (int i = 0; i < len; i++) pt.push_back(8'($urandom));
    send_msg(pt, 1'b0);
    ct = rxq;
    chk(ct.size() == len, "R9 ciphertext count", ct.size(), len);
    send_msg(ct, 1'b1);
    chk(rxq.size() == len, "R9 plaintext count", rxq.size(), len);
    for (int i = 0; i < len && i < rxq.size(); i++)
      chk(rxq[i] == pt[i], "R9 loopback byte", rxq[i], pt[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dir = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = '0; out_ready = 1'b0;
    ma = 8'h9B; mb = 8'h54; m_v = 1'b0; m_d = '0; m_tag = "";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R6: first byte after reset without start flag uses the seeds
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk(out_data == fwd(8'h00, 8'h9B, 8'h54), "R6 reset seeds", out_data, fwd(8'h00, 8'h9B, 8'h54));
    // stalled start byte waits, then uses the seeds when taken (R6, R8)
    cycle(1'b1, 8'h5C, 1'b1, 1'b1, 1'b0);
    cycle(1'b1, 8'h5C, 1'b1, 1'b1, 1'b0);
    cycle(1'b1, 8'h5C, 1'b1, 1'b1, 1'b1);
    cycle(1'b1, 8'h5C, 1'b1, 1'b1, 1'b1);
    flush();

    // R9 loopback at both length bounds
    loopback(1);
    loopback(64);
    loopback(17);

    // random traffic: idle gaps, stalls, mixed direction and length (R10, R8)
    for (int m = 0; m < 150; m++) begin
      int len;
      logic md;
      len = 1 + int'($urandom_range(63));
      md = 1'($urandom);
      for (int i = 0; i < len; ) begin
        logic iv, r;
        iv = ($urandom_range(3) != 0);
        r  = ($urandom_range(2) != 0);
        if (iv && (!m_v || r)) begin
          cycle(1'b1, 8'($urandom), i == 0, md, r);
          i++;
        end else begin
          cycle(iv, 8'($urandom), i == 0, md, r);
        end
      end
    end
    flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule